// File: doc/BRIEF.md
# Operand Addressing-Mode Fetch Unit

This block takes the two 6-bit operand fields of an instruction and carries out the operand traffic they call for on a machine with sixteen 16-bit registers. The source field is read first and the destination field is written afterwards with the source value. Opcode decoding and ALU work happen elsewhere, so the block behaves as a move. Along the way it pulls extension words from the instruction stream through its own program counter, forms effective addresses, issues byte or word reads and writes to a data memory, and bumps address registers in post-increment mode.

Each field selects one of six modes. Register mode reaches any of R0 to R15. Indirect, post-increment and indexed modes use address registers R8 to R15 and carry a byte/word bit. Two encodings that would name the stack pointer R15 in an unsupported way are reused: one gives an immediate operand and the other a direct memory address. An encoding that cannot be carried out raises a one-cycle illegal flag and leaves every register, memory word and the program counter untouched.

The register file, data memory and instruction stream are external. All three answer reads in the same cycle. The register file and data memory take writes on the clock edge.

Top module: `opf_unit`

## Requirements
- R1: After reset, busy, wb_done and illegal are low and the program counter shown on fetch_addr is 0.
- R2: Field encoding 00rrrr selects register r (R0 to R15) as a 16-bit word operand. As a source it is read through the register port. As a destination it is written with the source value.
- R3: Source field 011111 is an immediate operand. Its value is the next instruction-stream word.
- R4: Every extension word is fetched at the program counter, which then advances by 2. When both fields need one, the source extension word is fetched first and the destination extension word after it.
- R5: Encoding 10b111 is direct mode. The next stream word is the byte address and b selects byte (1) or word (0). R15 is neither read as an address nor modified.
- R6: Encoding 01brrr (other than 011111) is indirect mode. The byte address is held in register 8+rrr, and that register is not modified.
- R7: Encoding 10brrr with rrr other than 111 is post-increment mode. After the access, register 8+rrr is raised by 1 for a byte access or by 2 for a word access.
- R8: Encoding 11brrr is indexed mode. The byte address is register 8+rrr plus the next stream word taken as a signed offset, and the register is not modified.
- R9: A byte read returns the byte at address bit 0 (1 = high byte [15:8], 0 = low byte [7:0]), zero-extended. A byte write sets exactly one mem_be bit (bit 0 = low lane, bit 1 = high lane) with the byte on both lanes. A word access sets mem_be to 11.
- R10: A destination field of 011111, or either field equal to 111111, pulses illegal in the cycle after start. There is then no memory access, no register write, no fetch and no program-counter change, and wb_done does not pulse.
- R11: busy rises in the cycle after an accepted start. wb_done pulses for one cycle directly after the cycle that performs the destination write, and busy falls after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operand sequence (taken when not busy) |
| opd_word | input | 12 | Operand fields: [11:6] source, [5:0] destination |
| busy | output | 1 | Sequence in progress |
| pc_load | input | 1 | Load the program counter (taken when not busy) |
| pc_load_val | input | 16 | Program counter load value |
| fetch_req | output | 1 | Extension-word fetch this cycle |
| fetch_addr | output | 16 | Program counter / fetch byte address |
| fetch_data | input | 16 | Extension word returned in the same cycle |
| rf_raddr | output | 4 | Register read index |
| rf_rdata | input | 16 | Register read data |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 4 | Register write index |
| rf_wdata | output | 16 | Register write data |
| mem_req | output | 1 | Data memory access |
| mem_we | output | 1 | Data memory write (1) or read (0) |
| mem_addr | output | 16 | Data memory byte address |
| mem_be | output | 2 | Byte lane enables |
| mem_wdata | output | 16 | Data memory write data |
| mem_rdata | input | 16 | Data memory read data |
| src_val | output | 16 | Fetched source operand value |
| wb_done | output | 1 | Write-back completion strobe |
| illegal | output | 1 | Illegal encoding flag |

## Verification
A wrong mode decode shows within one instruction. A reused R15 encoding taken as post-increment or indirect reads the wrong address and corrupts R15. A misclassified extension need shifts the program counter by 2 and hands the destination the source's extension word. Wrong lane selection or a wrong increment step shows up as one wrong byte in memory or an address register off by one, and it can be seen as soon as wb_done pulses. A missed illegal case shows up in the same instruction as an unexpected write, fetch or completion strobe.

// File: rtl/opf_pkg.sv
package opf_pkg;
    localparam int DW    = 16;
    localparam int FW    = 6;
    localparam int RW    = 4;
    localparam int WORDW = 2 * FW;

    typedef enum logic [2:0] {
        AM_REG, AM_IMM, AM_DIR, AM_IND, AM_AINC, AM_IDX
    } amode_e;

    typedef struct packed {
        amode_e        mode;
        logic [RW-1:0] rsel;
        logic          is_byte;
        logic          need_ext;
        logic          is_mem;
        logic          bad;
    } opd_t;

    typedef enum logic [2:0] {
        ST_IDLE, ST_SEXT, ST_SACC, ST_DEXT, ST_DACC, ST_DONE, ST_ILL
    } st_e;

    function automatic opd_t decode_field(input logic [FW-1:0] f, input logic is_dst);
        opd_t o;
        o = '0;
        o.rsel = {1'b1, f[2:0]};
        o.is_byte = f[3];
        unique case (f[5:4])
            2'b00: begin
                o.mode = AM_REG;
                o.rsel = f[3:0];
                o.is_byte = 1'b0;
            end
            2'b01: begin
                if (f[3:0] == 4'hF) begin
                    o.mode = AM_IMM;
                    o.is_byte = 1'b0;
                    o.need_ext = 1'b1;
                    o.bad = is_dst;
                end else begin
                    o.mode = AM_IND;
                    o.is_mem = 1'b1;
                end
            end
            2'b10: begin
                o.is_mem = 1'b1;
                if (f[2:0] == 3'b111) begin
                    o.mode = AM_DIR;
                    o.need_ext = 1'b1;
                end else begin
                    o.mode = AM_AINC;
                end
            end
            default: begin
                o.mode = AM_IDX;
                o.is_mem = 1'b1;
                o.need_ext = 1'b1;
                o.bad = (f[3:0] == 4'hF);
            end
        endcase
        return o;
    endfunction
endpackage

// File: rtl/opf_field_dec.sv
module opf_field_dec
    import opf_pkg::*;
(
    input  logic [FW-1:0] fld,
    input  logic          is_dst,
    output opd_t          opd
);
    assign opd = decode_field(fld, is_dst);
endmodule

// File: rtl/opf_agen.sv
module opf_agen
    import opf_pkg::*;
(
    input  amode_e        mode,
    input  logic          is_byte,
    input  logic [DW-1:0] reg_val,
    input  logic [DW-1:0] ext_val,
    input  logic [DW-1:0] mem_rd,
    input  logic [DW-1:0] wr_val,
    output logic [DW-1:0] ea,
    output logic [DW-1:0] rd_val,
    output logic [1:0]    be,
    output logic [DW-1:0] wdata,
    output logic [DW-1:0] inc_val
);
    logic [7:0] lane_byte;

    always_comb begin
        unique case (mode)
            AM_DIR:  ea = ext_val;
            AM_IDX:  ea = reg_val + ext_val;
            default: ea = reg_val;
        endcase
        lane_byte = ea[0] ? mem_rd[15:8] : mem_rd[7:0];
        unique case (mode)
            AM_REG:  rd_val = reg_val;
            AM_IMM:  rd_val = ext_val;
            default: rd_val = is_byte ? {{(DW-8){1'b0}}, lane_byte} : mem_rd;
        endcase
        be      = is_byte ? (ea[0] ? 2'b10 : 2'b01) : 2'b11;
        wdata   = is_byte ? {wr_val[7:0], wr_val[7:0]} : wr_val;
        inc_val = reg_val + (is_byte ? DW'(1) : DW'(2));
    end
endmodule

// File: rtl/opf_ctrl.sv
module opf_ctrl
    import opf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WORDW-1:0] opd_word,
    input  logic             pc_load,
    input  logic [DW-1:0]    pc_load_val,
    input  logic [DW-1:0]    fetch_data,
    input  opd_t             s,
    input  opd_t             d,
    input  logic [DW-1:0]    rd_val,
    input  logic [DW-1:0]    inc_val,
    output logic [WORDW-1:0] act_word,
    output logic             busy,
    output logic             fetch_req,
    output logic [DW-1:0]    pc,
    output amode_e           cur_mode,
    output logic [RW-1:0]    cur_rsel,
    output logic             cur_byte,
    output logic [DW-1:0]    ext_q,
    output logic [DW-1:0]    src_q,
    output logic             rf_we,
    output logic [RW-1:0]    rf_waddr,
    output logic [DW-1:0]    rf_wdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic             wb_done,
    output logic             illegal
);
    st_e              st_q, st_n;
    logic [WORDW-1:0] word_q;
    logic             dphase;

    assign act_word = (st_q == ST_IDLE) ? opd_word : word_q;
    assign busy     = (st_q != ST_IDLE);
    assign dphase   = (st_q == ST_DEXT) || (st_q == ST_DACC);
    assign cur_mode = dphase ? d.mode    : s.mode;
    assign cur_rsel = dphase ? d.rsel    : s.rsel;
    assign cur_byte = dphase ? d.is_byte : s.is_byte;

    always_comb begin
        st_n      = st_q;
        fetch_req = 1'b0;
        rf_we     = 1'b0;
        rf_waddr  = cur_rsel;
        rf_wdata  = inc_val;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        wb_done   = 1'b0;
        illegal   = 1'b0;
        unique case (st_q)
            ST_IDLE: if (start) begin
                if (s.bad || d.bad) st_n = ST_ILL;
                else                st_n = s.need_ext ? ST_SEXT : ST_SACC;
            end
            ST_SEXT: begin
                fetch_req = 1'b1;
                st_n = ST_SACC;
            end
            ST_SACC: begin
                mem_req = s.is_mem;
                rf_we   = (s.mode == AM_AINC);
                st_n    = d.need_ext ? ST_DEXT : ST_DACC;
            end
            ST_DEXT: begin
                fetch_req = 1'b1;
                st_n = ST_DACC;
            end
            ST_DACC: begin
                mem_req = d.is_mem;
                mem_we  = d.is_mem;
                rf_we   = (d.mode == AM_AINC) || (d.mode == AM_REG);
                if (d.mode == AM_REG) rf_wdata = src_q;
                st_n = ST_DONE;
            end
            ST_DONE: begin
                wb_done = 1'b1;
                st_n = ST_IDLE;
            end
            default: begin
                illegal = 1'b1;
                st_n = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            word_q <= '0;
            pc     <= '0;
            ext_q  <= '0;
            src_q  <= '0;
        end else begin
            st_q <= st_n;
            if (st_q == ST_IDLE && start) word_q <= opd_word;
            if (st_q == ST_IDLE && pc_load) pc <= pc_load_val;
            if (fetch_req) begin
                ext_q <= fetch_data;
                pc    <= pc + DW'(2);
            end
            if (st_q == ST_SACC) src_q <= rd_val;
        end
    end

    AST_ILL_QUIET: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !mem_req && !rf_we && !fetch_req && !wb_done);          // R10
    AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
        fetch_req |=> pc == $past(pc) + DW'(2));                             // R4
    AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));                                        // R11
    AST_WB_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
        wb_done |-> $past((mem_req && mem_we) || rf_we));                    // R11
endmodule

// File: rtl/opf_unit.sv
module opf_unit
    import opf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [WORDW-1:0] opd_word,
    output logic             busy,
    input  logic             pc_load,
    input  logic [DW-1:0]    pc_load_val,
    output logic             fetch_req,
    output logic [DW-1:0]    fetch_addr,
    input  logic [DW-1:0]    fetch_data,
    output logic [RW-1:0]    rf_raddr,
    input  logic [DW-1:0]    rf_rdata,
    output logic             rf_we,
    output logic [RW-1:0]    rf_waddr,
    output logic [DW-1:0]    rf_wdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [DW-1:0]    mem_addr,
    output logic [1:0]       mem_be,
    output logic [DW-1:0]    mem_wdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic [DW-1:0]    src_val,
    output logic             wb_done,
    output logic             illegal
);
    logic [WORDW-1:0] act_word;
    opd_t             fld_dec [2];
    amode_e           cur_mode;
    logic [RW-1:0]    cur_rsel;
    logic             cur_byte;
    logic [DW-1:0]    ext_q, src_q, rd_val, inc_val;

    // index 0 decodes the destination field, index 1 the source field
    for (genvar g = 0; g < 2; g++) begin : g_dec
        opf_field_dec u_dec (
            .fld    (act_word[g*FW +: FW]),
            .is_dst (1'(g == 0)),
            .opd    (fld_dec[g])
        );
    end

    opf_ctrl u_ctrl (
        .clk(clk), .rst(rst), .start(start), .opd_word(opd_word),
        .pc_load(pc_load), .pc_load_val(pc_load_val), .fetch_data(fetch_data),
        .s(fld_dec[1]), .d(fld_dec[0]), .rd_val(rd_val), .inc_val(inc_val),
        .act_word(act_word), .busy(busy), .fetch_req(fetch_req), .pc(fetch_addr),
        .cur_mode(cur_mode), .cur_rsel(cur_rsel), .cur_byte(cur_byte),
        .ext_q(ext_q), .src_q(src_q), .rf_we(rf_we), .rf_waddr(rf_waddr),
        .rf_wdata(rf_wdata), .mem_req(mem_req), .mem_we(mem_we),
        .wb_done(wb_done), .illegal(illegal)
    );

    opf_agen u_agen (
        .mode(cur_mode), .is_byte(cur_byte), .reg_val(rf_rdata), .ext_val(ext_q),
        .mem_rd(mem_rdata), .wr_val(src_q), .ea(mem_addr), .rd_val(rd_val),
        .be(mem_be), .wdata(mem_wdata), .inc_val(inc_val)
    );

    assign rf_raddr = cur_rsel;
    assign src_val  = src_q;

    AST_BYTE_LANE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_be != 2'b11)
            |-> $countones(mem_be) == 1 && mem_wdata[15:8] == mem_wdata[7:0]); // R9
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(wb_done && illegal));                                                 // R11
endmodule

// File: tb/opf_unit_tb.sv
module opf_unit_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 0, rst = 1, start = 0, pc_load = 0;
    logic [11:0] opd_word = '0;
    logic [15:0] pc_load_val = '0;
    logic        busy, fetch_req, rf_we, mem_req, mem_we, wb_done, illegal;
    logic [15:0] fetch_addr, fetch_data, rf_rdata, rf_wdata, mem_addr, mem_wdata, mem_rdata, src_val;
    logic [3:0]  rf_raddr, rf_waddr;
    logic [1:0]  mem_be;

    logic [15:0] rf [16];
    logic [15:0] dmem [256];
    logic [15:0] imem [64];
    int checks = 0, errors = 0, n_mem = 0, n_rfw = 0, n_if = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opf_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .opd_word(opd_word), .busy(busy),
        .pc_load(pc_load), .pc_load_val(pc_load_val), .fetch_req(fetch_req),
        .fetch_addr(fetch_addr), .fetch_data(fetch_data), .rf_raddr(rf_raddr),
        .rf_rdata(rf_rdata), .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .src_val(src_val),
        .wb_done(wb_done), .illegal(illegal)
    );

    assign rf_rdata   = rf[rf_raddr];
    assign mem_rdata  = dmem[mem_addr[8:1]];
    assign fetch_data = imem[fetch_addr[6:1]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rf_we) rf[rf_waddr] <= rf_wdata;
        if (mem_req && mem_we) begin
            if (mem_be[0]) dmem[mem_addr[8:1]][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) dmem[mem_addr[8:1]][15:8] <= mem_wdata[15:8];
        end
        if (mem_req) n_mem <= n_mem + 1;
        if (rf_we) n_rfw <= n_rfw + 1;
        if (fetch_req) n_if <= n_if + 1;
    end

    task automatic check(input logic ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [11:0] mk(input logic [5:0] src, input logic [5:0] dst);
        return {src, dst};
    endfunction

    task automatic set_pc(input logic [15:0] v);
        @(negedge clk); pc_load = 1; pc_load_val = v;
        @(negedge clk); pc_load = 0;
    endtask

    task automatic run(input logic [11:0] w, output logic done, output logic ill);
        @(negedge clk);
        opd_word = w; start = 1;
        n_mem = 0; n_rfw = 0; n_if = 0;
        @(negedge clk);
        start = 0;
        check(busy, "R11 busy after start", 16'(busy), 16'h1);
        done = 0; ill = 0;
        for (int i = 0; i < 16 && !done && !ill; i++) begin
            if (wb_done) done = 1;
            else if (illegal) ill = 1;
            else @(negedge clk);
        end
        if (!done && !ill) check(1'b0, "R11 sequence timeout", 16'h0, 16'h1);
    endtask

    task automatic t_reset;
        check(!busy && !wb_done && !illegal, "R1 reset outputs",
              {13'h0, busy, wb_done, illegal}, 16'h0);
        check(fetch_addr == 16'h0, "R1 reset pc", fetch_addr, 16'h0);
    endtask

    task automatic t_reg_move;
        logic dn, il;
        logic [15:0] pc0;
        rf[3] = 16'h1234; rf[7] = 16'h0;
        pc0 = fetch_addr;
        run(mk(6'b000011, 6'b000111), dn, il);
        check(dn, "R2 reg move done", 16'(dn), 16'h1);
        check(rf[7] == 16'h1234, "R2 reg dest", rf[7], 16'h1234);
        check(src_val == 16'h1234, "R2 src_val", src_val, 16'h1234);
        check(n_if == 0 && fetch_addr == pc0, "R4 no fetch for reg", fetch_addr, pc0);
        @(negedge clk);
        check(!busy && !wb_done, "R11 strobe one cycle", {14'h0, busy, wb_done}, 16'h0);
    endtask

    task automatic t_immediate;
        logic dn, il;
        set_pc(16'h0010);
        imem[8] = 16'hBEEF;
        run(mk(6'b011111, 6'b000010), dn, il);
        check(rf[2] == 16'hBEEF, "R3 immediate", rf[2], 16'hBEEF);
        check(fetch_addr == 16'h0012, "R4 pc after imm", fetch_addr, 16'h0012);
    endtask

    task automatic t_direct_both;
        logic dn, il;
        set_pc(16'h0020);
        imem[16] = 16'h0040; imem[17] = 16'h0051;
        dmem[8'h20] = 16'h5A3C; dmem[8'h28] = 16'h1111;
        rf[15] = 16'h0200;
        run(mk(6'b100111, 6'b101111), dn, il);
        check(src_val == 16'h5A3C, "R5 direct word read / R4 source ext first", src_val, 16'h5A3C);
        check(dmem[8'h28] == 16'h3C11, "R9 direct byte high lane write", dmem[8'h28], 16'h3C11);
        check(rf[15] == 16'h0200, "R5 R15 untouched", rf[15], 16'h0200);
        check(fetch_addr == 16'h0024, "R4 two ext words", fetch_addr, 16'h0024);
    endtask

    task automatic t_ainc_byte;
        logic dn, il;
        rf[9] = 16'h0063; dmem[8'h31] = 16'hC7E2;
        run(mk(6'b101001, 6'b000100), dn, il);
        check(rf[4] == 16'h00C7, "R9 byte read zero-extended high", rf[4], 16'h00C7);
        check(rf[9] == 16'h0064, "R7 byte post-increment", rf[9], 16'h0064);
    endtask

    task automatic t_ind_ainc_word;
        logic dn, il;
        rf[10] = 16'h0080; dmem[8'h40] = 16'h7777;
        rf[11] = 16'h0090; dmem[8'h48] = 16'h0;
        run(mk(6'b010010, 6'b100011), dn, il);
        check(dmem[8'h48] == 16'h7777, "R6 indirect to autoinc write", dmem[8'h48], 16'h7777);
        check(rf[10] == 16'h0080, "R6 indirect reg unchanged", rf[10], 16'h0080);
        check(rf[11] == 16'h0092, "R7 word post-increment", rf[11], 16'h0092);
    endtask

    task automatic t_indexed;
        logic dn, il;
        set_pc(16'h0030);
        imem[24] = 16'hFFF0;
        rf[12] = 16'h0100; dmem[8'h78] = 16'h2468;
        run(mk(6'b110100, 6'b000001), dn, il);
        check(rf[1] == 16'h2468, "R8 indexed negative offset", rf[1], 16'h2468);
        check(rf[12] == 16'h0100, "R8 index reg unchanged", rf[12], 16'h0100);
        check(fetch_addr == 16'h0032, "R4 pc after index", fetch_addr, 16'h0032);
    endtask

    task automatic t_byte_low_write;
        logic dn, il;
        rf[5] = 16'hABCD; rf[14] = 16'h00A0; dmem[8'h50] = 16'hFFFF;
        run(mk(6'b000101, 6'b011110), dn, il);
        check(dmem[8'h50] == 16'hFFCD, "R9 byte low lane write", dmem[8'h50], 16'hFFCD);
    endtask

    task automatic t_illegal(input logic [11:0] w, input string tag);
        logic dn, il;
        logic [15:0] pc0, r1;
        pc0 = fetch_addr; r1 = rf[1];
        run(w, dn, il);
        check(il && !dn, {"R10 flag ", tag}, {14'h0, dn, il}, 16'h1);
        check(n_mem == 0 && n_rfw == 0 && n_if == 0, {"R10 no side effects ", tag},
              16'(n_mem + n_rfw + n_if), 16'h0);
        @(negedge clk);
        check(fetch_addr == pc0 && rf[1] == r1 && !wb_done, {"R10 state kept ", tag},
              fetch_addr, pc0);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) rf[i] = 16'h0;
        for (int i = 0; i < 256; i++) dmem[i] = 16'h0;
        for (int i = 0; i < 64; i++) imem[i] = 16'h0;
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_reg_move();
        t_immediate();
        t_direct_both();
        t_ainc_byte();
        t_ind_ainc_word();
        t_indexed();
        t_byte_low_write();
        t_illegal(mk(6'b000000, 6'b011111), "imm dest");
        t_illegal(mk(6'b111111, 6'b000001), "src 111111");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        wait (cyc > 20000);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected below 20000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule